// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the oversampling tick that a serial channel uses to shift out transmit bits and to sample incoming data. The reference clock first passes through a prescaler that can be set to pass every clock or one clock in four. The prescaled clock then drives a divider whose divisor has a 16-bit whole part and a 4-bit fraction in steps of one sixteenth.

The fraction works by stretching some tick periods by one prescaled clock. A small phase accumulator decides which periods are stretched, so that over every sixteen ticks exactly as many periods are stretched as the fraction code says. A second counter marks the bit boundary on every 16th tick or on every 8th tick, depending on the oversampling mode. A resynchronising input restarts that count, for example on a receive start edge.

Divisor changes are picked up only at a tick boundary. This means a period that is already running always finishes at its old length. The serial shifters, the FIFOs and the register bus decoding live elsewhere.

Top module: `frac_baud_gen`

## Requirements
- R1: With fraction 0 and prescaler off, `tick` is a one-cycle pulse repeating every W clocks. W is the whole divisor `{div_hi, div_lo}`, with `div_hi` as the upper byte, so 0x1234 gives 4660 clocks.
- R2: With `presc_sel` = 1, every tick period is four times as many reference clocks as with `presc_sel` = 0, for the same divisor.
- R3: With fraction code n (0..15), each tick period is either W or W+1 prescaled clocks. Any 256 consecutive ticks span exactly (16·W + n)·16·P reference clocks, where P is 1 or 4.
- R4: A whole divisor of 0 behaves as 1: the tick never stalls, and 256 ticks take (16 + n)·16·P clocks.
- R5: A divisor change made in the middle of a period does not shorten or lengthen that period. The new value governs the period that starts at the next tick, and the fraction accumulator restarts from zero there.
- R6: With `osr16_sel` = 1, `bit_strobe` pulses on every 16th tick. With `osr16_sel` = 0, it pulses on every 8th tick. It is only ever high in a cycle where `tick` is high.
- R7: A one-cycle `resync` pulse restarts the strobe count. After it, the first `bit_strobe` comes on the 16th (or 8th) tick, and `bit_strobe` is low in the cycle after `resync`.
- R8: In 8X mode with an odd fraction, consecutive bit-strobe intervals differ by at most one prescaled clock. For W = 4 and n = 1, every interval is 32 or 33 clocks, and 16 consecutive intervals sum to 520.
- R9: While `rst_n` is low, `tick` and `bit_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_lo | input | 8 | Low byte of the whole divisor |
| div_hi | input | 8 | High byte of the whole divisor |
| div_frac | input | 4 | Fraction code, n sixteenths |
| presc_sel | input | 1 | 1 = divide reference clock by 4, 0 = by 1 |
| osr16_sel | input | 1 | 1 = 16 ticks per bit, 0 = 8 ticks per bit |
| resync | input | 1 | Restarts the bit-boundary count |
| tick | output | 1 | One-cycle oversampling tick |
| bit_strobe | output | 1 | One-cycle bit-boundary pulse, aligned with a tick |

## Verification
The bench sweeps whole divisors, every fraction class (zero, odd, half, maximum), both prescaler settings and both modes. For each combination it counts reference clocks over 256 ticks exactly. A wrong accumulator carry, an off-by-one period, or a prescaler pulse at the wrong ratio each shift that total by a predictable amount.

It also checks that a zero divisor does not stall the tick, and that a divisor rewritten mid-period does not clip the running period; a design that reloads at once would emit a runt. It confirms that the strobe lands exactly on the 16th or 8th tick after a resync. Finally, it checks that 8X-mode strobe intervals with an odd fraction only alternate between two adjacent lengths, where a misordered carry would give a wider spread.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BAUD_WHOLE_W = 16;
  localparam int BAUD_FRAC_W  = 4;
  localparam int BAUD_PRESC   = 4;
  localparam int BAUD_OSR_HI  = 16;
  localparam int BAUD_OSR_LO  = 8;
  localparam int BAUD_BCNT_W  = $clog2(BAUD_OSR_HI);

  typedef enum logic {
    OSR_8X  = 1'b0,
    OSR_16X = 1'b1
  } osr_mode_e;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int RATIO = baud_pkg::BAUD_PRESC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic en_o
);
  generate
    if (RATIO <= 1) begin : g_bypass
      assign en_o = 1'b1;
    end else begin : g_count
      localparam int PW = $clog2(RATIO);
      localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
      logic [PW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = '0;
        if (sel_i) begin
          cnt_d = (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign en_o = !sel_i || (cnt_q == LAST);

      // R2
      presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && en_o) |=> (!sel_i || !en_o));
    end
  endgenerate
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int WHOLE_W = baud_pkg::BAUD_WHOLE_W,
  parameter int FRAC_W  = baud_pkg::BAUD_FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [WHOLE_W-1:0] whole_i,
  input  logic [FRAC_W-1:0]  frac_i,
  output logic               tick_now_o,
  output logic               tick_o
);
  localparam int CNT_W = WHOLE_W + 1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   len_q, len_d;
  logic [FRAC_W-1:0]  acc_q, acc_d;
  logic [WHOLE_W-1:0] whole_q, whole_d;
  logic [FRAC_W-1:0]  frac_q, frac_d;
  logic               tick_q;

  logic [WHOLE_W-1:0] whole_eff;
  logic [WHOLE_W-1:0] weff_q;
  logic               cfg_changed;
  logic [FRAC_W-1:0]  acc_base;
  logic [FRAC_W:0]    acc_sum;

  assign whole_eff   = (whole_i == '0) ? WHOLE_W'(1) : whole_i;
  assign weff_q      = (whole_q == '0) ? WHOLE_W'(1) : whole_q;
  assign cfg_changed = (whole_i != whole_q) || (frac_i != frac_q);
  assign acc_base    = cfg_changed ? '0 : acc_q;
  assign acc_sum     = {1'b0, acc_base} + {1'b0, frac_i};
  assign tick_now_o  = en_i && (cnt_q == len_q);

  always_comb begin
    cnt_d   = cnt_q;
    len_d   = len_q;
    acc_d   = acc_q;
    whole_d = whole_q;
    frac_d  = frac_q;
    if (tick_now_o) begin
      cnt_d   = '0;
      acc_d   = acc_sum[FRAC_W-1:0];
      len_d   = CNT_W'(whole_eff) - CNT_W'(1) + CNT_W'(acc_sum[FRAC_W]);
      whole_d = whole_i;
      frac_d  = frac_i;
    end else if (en_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= '0;
      acc_q   <= '0;
      whole_q <= WHOLE_W'(1);
      frac_q  <= '0;
      tick_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      acc_q   <= acc_d;
      whole_q <= whole_d;
      frac_q  <= frac_d;
      tick_q  <= tick_now_o;
    end
  end

  assign tick_o = tick_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_q);

  // R3
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == CNT_W'(weff_q) - CNT_W'(1)) || (len_q == CNT_W'(weff_q)));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_now_o |=> ($stable(whole_q) && $stable(frac_q)));
endmodule

// File: rtl/baud_bit_strobe.sv
module baud_bit_strobe #(
  parameter int BCNT_W = baud_pkg::BAUD_BCNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic osr16_i,
  input  logic resync_i,
  output logic strobe_o
);
  import baud_pkg::*;

  osr_mode_e         mode;
  logic [BCNT_W-1:0] last;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              strobe_q, strobe_d;

  assign mode = osr_mode_e'(osr16_i);
  assign last = (mode == OSR_16X) ? BCNT_W'(BAUD_OSR_HI - 1) : BCNT_W'(BAUD_OSR_LO - 1);

  always_comb begin
    bcnt_d   = bcnt_q;
    strobe_d = 1'b0;
    if (resync_i) begin
      bcnt_d = '0;
    end else if (tick_i) begin
      if (bcnt_q >= last) begin
        bcnt_d   = '0;
        strobe_d = 1'b1;
      end else begin
        bcnt_d = bcnt_q + BCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      bcnt_q   <= bcnt_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe_o = strobe_q;

  // R7
  resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> !strobe_o);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] div_lo,
  input  logic [7:0] div_hi,
  input  logic [3:0] div_frac,
  input  logic       presc_sel,
  input  logic       osr16_sel,
  input  logic       resync,
  output logic       tick,
  output logic       bit_strobe
);
  import baud_pkg::*;

  logic                    presc_en;
  logic                    tick_now;
  logic [BAUD_WHOLE_W-1:0] whole;

  assign whole = {div_hi, div_lo};

  baud_prescale #(.RATIO(BAUD_PRESC)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (presc_sel),
    .en_o  (presc_en)
  );

  baud_frac_div #(.WHOLE_W(BAUD_WHOLE_W), .FRAC_W(BAUD_FRAC_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (presc_en),
    .whole_i    (whole),
    .frac_i     (div_frac),
    .tick_now_o (tick_now),
    .tick_o     (tick)
  );

  baud_bit_strobe #(.BCNT_W(BAUD_BCNT_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_now),
    .osr16_i  (osr16_sel),
    .resync_i (resync),
    .strobe_o (bit_strobe)
  );

  // R6
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> tick);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!tick && !bit_strobe) || rst_n);
endmodule

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div_lo, div_hi;
  logic [3:0] div_frac;
  logic       presc_sel, osr16_sel, resync;
  logic       tick, bit_strobe;

  int chk  = 0;
  int fail = 0;

  always #10 clk = ~clk;

  frac_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
    .div_frac(div_frac), .presc_sel(presc_sel), .osr16_sel(osr16_sel),
    .resync(resync), .tick(tick), .bit_strobe(bit_strobe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chk++;
    if (!ok) begin
      fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int w, input int f, input bit p, input bit m);
    div_lo    = w[7:0];
    div_hi    = w[15:8];
    div_frac  = f[3:0];
    presc_sel = p;
    osr16_sel = m;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  task automatic measure(input int w, input int f, input bit p, input bit m);
    int cyc = 0, t = 0, s = 0, bad = 0, weff, exp_c;
    set_cfg(w, f, p, m);
    wait_ticks(2);
    while (t < 256) begin
      @(negedge clk);
      cyc++;
      if (tick) t++;
      if (bit_strobe) begin
        s++;
        if (!tick) bad++;
      end
    end
    weff  = (w == 0) ? 1 : w;
    exp_c = (16 * weff + f) * 16 * (p ? 4 : 1);
    check(cyc == exp_c, $sformatf("R1 R2 R3 R4 clocks per 256 ticks w=%0d f=%0d p=%0d", w, f, p), cyc, exp_c);
    check(s == 256 / (m ? 16 : 8), $sformatf("R6 strobes per 256 ticks m=%0d", m), s, 256 / (m ? 16 : 8));
    check(bad == 0, "R6 strobe without tick", bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog R1 run length", 190000, 0);
    $display("%0d/%0d checks passed", chk - fail, chk);
    $finish;
  end

  initial begin
    int wl[3] = '{1, 2, 5};
    int fl[4] = '{0, 3, 8, 15};
    int n, bad, sum;
    rst_n  = 1'b0;
    resync = 1'b0;
    set_cfg(1, 0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check(!tick && !bit_strobe, "R9 outputs during reset", {tick, bit_strobe}, 0);
    rst_n = 1'b1;

    foreach (wl[i]) foreach (fl[j])
      for (int p = 0; p < 2; p++)
        for (int m = 0; m < 2; m++)
          measure(wl[i], fl[j], p[0], m[0]);

    // R4 zero whole divisor
    measure(0, 0, 1'b0, 1'b1);
    measure(0, 8, 1'b1, 1'b0);

    // R5 mid-period change keeps running period
    set_cfg(40, 0, 1'b0, 1'b1);
    wait_ticks(2);
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    set_cfg(3, 0, 1'b0, 1'b1);
    do begin @(negedge clk); n++; end while (!tick);
    check(n == 40, "R5 running period after change", n, 40);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
    check(n == 3, "R5 first period with new divisor", n, 3);

    // R7 resync then strobe on 16th tick
    wait_ticks(1);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    check(!bit_strobe, "R7 strobe after resync", bit_strobe, 0);
    bad = 0;
    for (int k = 1; k <= 48; k++) begin
      do @(negedge clk); while (!tick);
      if (bit_strobe != ((k % 16) == 0)) bad++;
    end
    check(bad == 0, "R7 strobe on 16th ticks after resync", bad, 0);

    // R8 8X odd fraction jitter
    set_cfg(4, 1, 1'b0, 1'b0);
    wait_ticks(2);
    do @(negedge clk); while (!bit_strobe);
    bad = 0;
    sum = 0;
    for (int k = 0; k < 16; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!bit_strobe);
      if (n != 32 && n != 33) bad++;
      sum += n;
    end
    check(bad == 0, "R8 strobe interval outside 32..33", bad, 0);
    check(sum == 520, "R8 sum of 16 strobe intervals", sum, 520);

    // R1 high byte of whole divisor
    set_cfg(16'h1234, 0, 1'b0, 1'b1);
    wait_ticks(2);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
    check(n == 4660, "R1 period with 0x1234", n, 4660);

    $display("%0d/%0d checks passed", chk - fail, chk);
    $finish;
  end
endmodule